// File: doc/BRIEF.md
# Serial Dual Wiper Code Register

This block is the digital front end of a pair of 256-step digital potentiometers. A host talks to it over three lines: an enable that frames a transaction, a serial clock, and a data line. While the enable is high, each rising edge of the serial clock moves one data bit into a 17-stage shift register. When the enable falls, the register contents become the new settings: two 8-bit wiper codes and one stack select bit. The stack select bit steers a one-hot multiplexer select and the multiplexed wiper code.

The bit that leaves the far end of the shift register is driven on a cascade output. Several devices can therefore be chained, each cascade output feeding the next device's data input, and one host can load all of them in a single long transaction. When a transaction starts, the shift register is loaded with the present settings, so that the cascade output also reads those settings back one bit per serial clock.

The three host lines are asynchronous to the block clock. They pass through a synchronizer of `SYNC_STAGES` flops, and all edges are detected in the block clock domain. Outputs follow a host line change after `SYNC_STAGES + 1` block clock cycles.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: After `rst_n` is asserted, `wiper0`, `wiper1` and `stack_sel` are 0, `mux_sel` is 2'b01, `mux_code` is 0 and `ser_dout` is 0.
- R2: While `ser_en` is high, every rising edge of `ser_clk` shifts `ser_din` into the shift register. The frame is 17 bits, sent in this order: the stack select bit first, then the 8 bits of the wiper 1 code most significant bit first, then the 8 bits of the wiper 0 code most significant bit first.
- R3: A falling edge of `ser_en` copies the shift register into `stack_sel`, `wiper1` and `wiper0`. These outputs do not change at any other time.
- R4: With `stack_sel` at 0, `mux_sel` is 2'b01 and `mux_code` equals `wiper0`. With `stack_sel` at 1, `mux_sel` is 2'b10 and `mux_code` equals `wiper1`.
- R5: `ser_dout` is the last shift register stage. When a frame is longer than 17 bits, the earliest bits leave on `ser_dout` in the order they were sent, and the last 17 bits sent are the ones committed.
- R6: When fewer than 17 clocks arrive in a transaction, the preloaded contents move on by that number of places. The commit then takes whatever the register holds.
- R7: A rising edge of `ser_en` loads the shift register with the present settings. `ser_dout` then presents `stack_sel` at once, followed by one further bit of `wiper1` and then `wiper0` (MSB first) after each `ser_clk` rising edge.
- R8: Rising edges of `ser_clk` while `ser_en` is low change neither the outputs nor the shift register contents.
- R9: A `ser_clk` rising edge that reaches the block in the same clock cycle as a falling `ser_en` edge is ignored, and the commit takes the unshifted contents. A `ser_clk` rising edge that arrives together with a rising `ser_en` edge is also ignored, and only the preload takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Transaction enable from host, high while a transaction is active |
| ser_clk | input | 1 | Serial clock from host |
| ser_din | input | 1 | Serial data from host or from the previous device |
| ser_dout | output | 1 | Cascade output, last shift register stage |
| wiper0 | output | 8 | Committed wiper 0 code |
| wiper1 | output | 8 | Committed wiper 1 code |
| stack_sel | output | 1 | Committed stack select bit |
| mux_sel | output | 2 | One-hot select, 2'b01 for wiper 0, 2'b10 for wiper 1 |
| mux_code | output | 8 | Code of the selected wiper |

## Verification
A serial clock edge can land in the same synchronized cycle as an enable edge, either at the end of a transaction (commit versus shift) or at its start (preload versus shift). The bench provokes both by changing the enable line and the serial clock line in the same time step, so the two changes pass the synchronizer together. The behavioural queue model drops the shift in either case. The committed codes, the multiplexer outputs and the cascade bit are then compared clock by clock against that model, and a shift that is wrongly applied shows up as a displaced code.

// File: rtl/dwr_pkg.sv
package dwr_pkg;

  localparam int DWR_CODE_W  = 8;
  localparam int DWR_FRAME_W = 1 + 2 * DWR_CODE_W;

  typedef logic [DWR_CODE_W-1:0] code_t;

  // Field order matches shift order: stack bit leaves the register first.
  typedef struct packed {
    logic  stack;
    code_t w1;
    code_t w0;
  } frame_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_POT0 = 2'b01,
    SEL_POT1 = 2'b10
  } mux_sel_e;

  function automatic frame_t bits_to_frame(logic [DWR_FRAME_W-1:0] bits);
    return frame_t'(bits);
  endfunction

  function automatic logic [DWR_FRAME_W-1:0] frame_to_bits(frame_t f);
    return {f.stack, f.w1, f.w0};
  endfunction

  function automatic mux_sel_e select_of(logic stack);
    return stack ? SEL_POT1 : SEL_POT0;
  endfunction

  function automatic code_t pick_code(frame_t f);
    return f.stack ? f.w1 : f.w0;
  endfunction

endpackage

// File: rtl/dwr_sync.sv
module dwr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign sync_out = chain[LAST];

endmodule

// File: rtl/dwr_edges.sv
module dwr_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic sclk_s,
  output logic ev_load,
  output logic ev_commit,
  output logic ev_shift
);

  logic en_prev;
  logic sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev   <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      en_prev   <= en_s;
      sclk_prev <= sclk_s;
    end
  end

  logic sclk_rise;
  assign sclk_rise = sclk_s & ~sclk_prev;

  assign ev_load   = en_s & ~en_prev;
  assign ev_commit = ~en_s & en_prev;
  // A transaction edge takes precedence over a serial clock edge in the same cycle.
  assign ev_shift  = sclk_rise & en_s & en_prev;

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_load, ev_commit, ev_shift}) <= 1); // R9

endmodule

// File: rtl/dwr_shifter.sv
module dwr_shifter
  import dwr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_load,
  input  logic                   ev_shift,
  input  logic                   din,
  input  logic [DWR_FRAME_W-1:0] preload,
  output logic [DWR_FRAME_W-1:0] stages,
  output logic                   dout
);

  localparam int TOP = DWR_FRAME_W - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stages <= '0;
    end else if (ev_load) begin
      stages <= preload;
    end else if (ev_shift) begin
      stages <= {stages[TOP-1:0], din};
    end
  end

  assign dout = stages[TOP];

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_load && !ev_shift) |=> $stable(stages)); // R8

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_shift && !ev_load) |=> (stages == {$past(stages[TOP-1:0]), $past(din)})); // R2

  AST_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (stages == $past(preload))); // R7

endmodule

// File: rtl/dwr_commit.sv
module dwr_commit
  import dwr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_commit,
  input  logic [DWR_FRAME_W-1:0] stages,
  output frame_t                 held
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (ev_commit) begin
      held <= bits_to_frame(stages);
    end
  end

  AST_COMMIT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> (frame_to_bits(held) == $past(stages))); // R3

  AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_commit |=> $stable(held)); // R3

endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
  import dwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_en,
  input  logic                  ser_clk,
  input  logic                  ser_din,
  output logic                  ser_dout,
  output logic [DWR_CODE_W-1:0] wiper0,
  output logic [DWR_CODE_W-1:0] wiper1,
  output logic                  stack_sel,
  output logic [1:0]            mux_sel,
  output logic [DWR_CODE_W-1:0] mux_code
);

  localparam int LINE_CNT = 3;

  logic [LINE_CNT-1:0] lines_s;
  logic en_s, sclk_s, din_s;

  // All three lines share one synchronizer so they stay aligned.
  dwr_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_en, ser_clk, ser_din}),
    .sync_out (lines_s)
  );

  assign {en_s, sclk_s, din_s} = lines_s;

  logic ev_load, ev_commit, ev_shift;

  dwr_edges edges_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (en_s),
    .sclk_s    (sclk_s),
    .ev_load   (ev_load),
    .ev_commit (ev_commit),
    .ev_shift  (ev_shift)
  );

  frame_t                 held;
  logic [DWR_FRAME_W-1:0] stages;

  dwr_shifter shifter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_load  (ev_load),
    .ev_shift (ev_shift),
    .din      (din_s),
    .preload  (frame_to_bits(held)),
    .stages   (stages),
    .dout     (ser_dout)
  );

  dwr_commit commit_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_commit (ev_commit),
    .stages    (stages),
    .held      (held)
  );

  assign wiper0    = held.w0;
  assign wiper1    = held.w1;
  assign stack_sel = held.stack;
  assign mux_sel   = select_of(held.stack);
  assign mux_code  = pick_code(held);

  AST_MUX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mux_sel) == 1); // R4

endmodule

// File: tb/dual_wiper_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_wiper_ctrl_tb_top;

  localparam int HOLD = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic       ser_dout, stack_sel;
  logic [7:0] wiper0, wiper1, mux_code;
  logic [1:0] mux_sel;

  always #4 clk = ~clk;

  dual_wiper_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .wiper0(wiper0), .wiper1(wiper1), .stack_sel(stack_sel),
    .mux_sel(mux_sel), .mux_code(mux_code)
  );

  int nchk = 0;
  int nerr = 0;

  // Behavioural model: a bit queue, front = next bit out on the cascade.
  bit       mq[$];
  bit [7:0] m_w0 = 0, m_w1 = 0;
  bit       m_st = 0;
  bit       ln_en = 0, ln_clk = 0;

  task automatic m_preload();
    mq.delete();
    mq.push_back(m_st);
    for (int i = 7; i >= 0; i--) mq.push_back(m_w1[i]);
    for (int i = 7; i >= 0; i--) mq.push_back(m_w0[i]);
  endtask

  task automatic m_commit();
    m_st = mq[0];
    for (int i = 0; i < 8; i++) m_w1[7-i] = mq[1+i];
    for (int i = 0; i < 8; i++) m_w0[7-i] = mq[9+i];
  endtask

  task automatic cmp(string tag, string name, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic chk(string tag);
    cmp(tag, "wiper0", wiper0, m_w0);
    cmp(tag, "wiper1", wiper1, m_w1);
    cmp(tag, "stack_sel", {7'd0, stack_sel}, {7'd0, m_st});
    cmp(tag, "mux_sel", {6'd0, mux_sel}, m_st ? 8'h02 : 8'h01);
    cmp(tag, "mux_code", mux_code, m_st ? m_w1 : m_w0);
    cmp(tag, "ser_dout", {7'd0, ser_dout}, {7'd0, mq[0]});
  endtask

  // Drive all three lines at once, update the model, then compare every clock once settled.
  task automatic step(bit e, bit c, bit d, string tag);
    @(negedge clk);
    if (e && !ln_en)                m_preload();
    else if (!e && ln_en)           m_commit();
    else if (e && c && !ln_clk) begin
      mq.push_back(d);
      void'(mq.pop_front());
    end
    ln_en = e; ln_clk = c;
    ser_en = e; ser_clk = c; ser_din = d;
    for (int i = 0; i < HOLD; i++) begin
      @(negedge clk);
      if (i >= 2) chk(tag);
    end
  endtask

  task automatic send_bit(bit b, string tag);
    step(1'b1, 1'b0, b, tag);
    step(1'b1, 1'b1, b, tag);
  endtask

  task automatic send_frame(bit st, bit [7:0] a, bit [7:0] b, string tag);
    step(1'b1, 1'b0, 1'b0, "R7");
    send_bit(st, tag);
    for (int i = 7; i >= 0; i--) send_bit(a[i], tag);
    for (int i = 7; i >= 0; i--) send_bit(b[i], tag);
    step(1'b1, 1'b0, 1'b0, tag);
    step(1'b0, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b0, "R4");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    m_preload();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1");
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R1");

    // R2 R3 R4: full frames with each stack select value
    send_frame(1'b0, 8'hA5, 8'h3C, "R2");
    send_frame(1'b1, 8'h5A, 8'hC3, "R2");
    send_frame(1'b1, 8'h00, 8'hFF, "R4");
    send_frame(1'b0, 8'h81, 8'h7E, "R4");

    // R7: readback, clock out the settings bit by bit with zeros behind them
    step(1'b1, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 17; i++) send_bit(1'b0, "R7");
    step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, "R7");

    // R5: overlong frame of 20 bits, early bits leave on the cascade
    send_frame(1'b1, 8'hC6, 8'h39, "R5");
    step(1'b1, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 20; i++) send_bit(i[0] ^ i[2], "R5");
    step(1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, "R5");

    // R6: short frame of 8 bits
    send_frame(1'b0, 8'h12, 8'h34, "R6");
    step(1'b1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 8; i++) send_bit(i[0], "R6");
    step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b0, "R6");

    // R8: serial clocks while enable is low
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b1, 1'b1, "R8");
      step(1'b0, 1'b0, 1'b0, "R8");
    end
    step(1'b1, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b0, "R8");

    // R9: clock rise together with enable fall
    step(1'b1, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 5; i++) send_bit(1'b1, "R9");
    step(1'b1, 1'b0, 1'b1, "R9");
    step(1'b0, 1'b1, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b0, "R9");
    // R9: clock rise together with enable rise
    step(1'b1, 1'b1, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 3; i++) send_bit(1'b0, "R9");
    step(1'b1, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b0, 1'b0, "R9");

    // R2: further frames with varied codes
    for (int k = 0; k < 6; k++) begin
      send_frame(1'($urandom), 8'($urandom), 8'($urandom), "R2");
    end

    summary();
    $finish;
  end

endmodule